// File: doc/BRIEF.md
# Toggle-Count and Residue Charge Merger

This block turns the raw outputs of a bipolar, fully differential integrating current-to-frequency converter into one signed charge figure per acquisition window. The converter gives two things. It emits a one-cycle toggle pulse each time the integrator crosses a threshold, and the branch status bit then changes side. It also delivers a stream of ADC samples of the integrator voltage. The merger counts the pulses as whole charge quanta and uses the ADC to measure the fraction left on the integrator. It then subtracts a programmable offset that compensates a constant injected or leakage current.

A window closes on every WIN_SAMPLES-th valid ADC sample (20 by default, which matches a 2 µs window at 10 Msps). The residue at the closing sample ends one window and also serves as the start of the next window, so consecutive windows have no gap. When the range controller holds the converter in reset during a window, the block emits a marker for that window in place of a merged value.

Top module: `toggle_residue_merger`

## Requirements
- R1: After reset, res_valid_o, res_data_o, res_ovf_o and res_hold_o are all 0.
- R2: Valid ADC samples (adc_valid_i high) are counted, and a window closes on the WIN_SAMPLES-th of them. res_valid_o is high for exactly one cycle, in the cycle after the closing sample. Cycles without a valid sample never advance the window.
- R3: For a window that is not held, res_data_o = N·q_step_i + (F_end − F_start) − offset_i, as a signed RES_W-bit value. N is the window's saturated net pulse count. F_end is the folded closing sample, and F_start is the folded closing sample of the previous window. q_step_i and offset_i are taken in the closing cycle.
- R4: A pulse seen with branch_i=0 adds +1 to N, and a pulse seen with branch_i=1 adds −1. Pulses count in every cycle, valid sample or not. A pulse in the closing cycle belongs to the closing window.
- R5: A sample is read as 16-bit two's complement (ADC_OFFSET_BIN=0). Its folded value F is the sample itself when branch_i=0 in its cycle and the negated sample when branch_i=1. The negation is exact for −32768.
- R6: Windows have no dead time. F_start of the first window after reset is 0, and each following window uses the previous closing sample's F. N restarts at 0 after every close.
- R7: N saturates at +(2^(CNT_W−1)−1) and −2^(CNT_W−1). Any pulse that would pass a limit sets res_ovf_o with that window's result. The next window starts with the flag clear.
- R8: If hold_i is high in any cycle of a window, from the cycle after the previous close up to and including the closing cycle, the result is a marker. The marker has res_hold_o=1, res_data_o=0 and res_ovf_o=0. The residue chain still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pulse_i | input | 1 | One-cycle threshold-crossing pulse |
| branch_i | input | 1 | Active integrator branch |
| adc_valid_i | input | 1 | ADC sample strobe |
| adc_data_i | input | ADC_W (16) | Integrator voltage sample |
| hold_i | input | 1 | Converter held in reset by range controller |
| q_step_i | input | Q_W (16) | Charge per pulse, unsigned |
| offset_i | input | RES_W (40) | Signed per-window offset to subtract |
| res_valid_o | output | 1 | Window result strobe |
| res_data_o | output | RES_W (40) | Signed window charge |
| res_ovf_o | output | 1 | Pulse count saturated in this window |
| res_hold_o | output | 1 | Window marked as held |

## Verification
The bench targets pulses that land in the closing cycle. A design that carried such a pulse into the next window would put one quantum in the wrong window. It checks samples taken on branch 1, including full-scale negative codes. A design that folded the wrong way or lost the 17th bit would give results off by twice the residue. It drives long pulse bursts in both directions past the count limits, which exposes a wrapping counter or a sticky flag that does not clear. It also drives hold pulses that fall between samples. A design that sampled hold only on sample cycles, or that froze the residue chain during a held window, would then shift every later result.

// File: rtl/merger_pkg.sv
package merger_pkg;
   // branch encoding: which side of the differential integrator is active
   typedef enum logic {
      BR_POS = 1'b0,
      BR_NEG = 1'b1
   } branch_e;
endpackage

// File: rtl/mrg_sat_cnt.sv
module mrg_sat_cnt #(
   parameter int W = 12
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                pulse_i,
   input  logic                dir_neg_i,
   input  logic                clr_i,
   output logic signed [W-1:0] cnt_nx_o,
   output logic                ovf_nx_o
);
   localparam logic signed [W:0]   ONE  = 1;
   localparam logic signed [W:0]   MAXW = (2 ** (W - 1)) - 1;
   localparam logic signed [W:0]   MINW = -(2 ** (W - 1));
   localparam logic signed [W-1:0] MAXV = MAXW[W-1:0];
   localparam logic signed [W-1:0] MINV = MINW[W-1:0];

   generate
      if (W < 2) begin : g_bad_w
         $error("mrg_sat_cnt: W must be at least 2");
      end
   endgenerate

   logic signed [W-1:0] cnt_q;
   logic                ovf_q;
   logic signed [W:0]   ext, wide;

   always_comb begin
      ext  = {cnt_q[W-1], cnt_q};
      wide = ext;
      if (pulse_i) wide = dir_neg_i ? (ext - ONE) : (ext + ONE);
      ovf_nx_o = ovf_q;
      if (wide > MAXW) begin
         cnt_nx_o = MAXV;
         ovf_nx_o = 1'b1;
      end else if (wide < MINW) begin
         cnt_nx_o = MINV;
         ovf_nx_o = 1'b1;
      end else begin
         cnt_nx_o = wide[W-1:0];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (clr_i) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         cnt_q <= cnt_nx_o;
         ovf_q <= ovf_nx_o;
      end
   end

   // R7
   sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == MAXV && pulse_i && !dir_neg_i && !clr_i) |=> (cnt_q == MAXV && ovf_q));
   // R7
   sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == MINV && pulse_i && dir_neg_i && !clr_i) |=> (cnt_q == MINV && ovf_q));
   // R6
   cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0 && !ovf_q));
endmodule

// File: rtl/mrg_residue.sv
module mrg_residue #(
   parameter int ADC_W      = 16,
   parameter bit OFFSET_BIN = 1'b0
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [ADC_W-1:0]      sample_i,
   input  logic                  branch_i,
   input  logic                  capture_i,
   output logic signed [ADC_W:0] fold_o,
   output logic signed [ADC_W:0] start_o
);
   import merger_pkg::*;

   logic [ADC_W-1:0]      val;
   logic signed [ADC_W:0] ext;

   generate
      if (OFFSET_BIN) begin : g_offbin
         assign val = {~sample_i[ADC_W-1], sample_i[ADC_W-2:0]};
      end else begin : g_twos
         assign val = sample_i;
      end
   endgenerate

   always_comb begin
      ext    = {val[ADC_W-1], val};
      fold_o = (branch_e'(branch_i) == BR_NEG) ? -ext : ext;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        start_o <= '0;
      else if (capture_i) start_o <= fold_o;
   end

   // R6
   chain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      capture_i |=> (start_o == $past(fold_o)));
   // R6
   chain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !capture_i |=> $stable(start_o));
endmodule

// File: rtl/mrg_win_seq.sv
module mrg_win_seq #(
   parameter int WIN_SAMPLES = 20
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic valid_i,
   output logic close_o
);
   localparam int IDX_W = (WIN_SAMPLES > 2) ? $clog2(WIN_SAMPLES) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(WIN_SAMPLES - 1);

   generate
      if (WIN_SAMPLES < 2) begin : g_bad_win
         $error("mrg_win_seq: WIN_SAMPLES must be at least 2");
      end
   endgenerate

   logic [IDX_W-1:0] idx_q;

   assign close_o = valid_i && (idx_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      idx_q <= '0;
      else if (close_o) idx_q <= '0;
      else if (valid_i) idx_q <= idx_q + 1'b1;
   end

   // R2
   idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idx_q <= LAST);
   // R2
   idx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(idx_q));
endmodule

// File: rtl/toggle_residue_merger.sv
module toggle_residue_merger #(
   parameter int ADC_W          = 16,
   parameter int WIN_SAMPLES    = 20,
   parameter int CNT_W          = 12,
   parameter int Q_W            = 16,
   parameter int RES_W          = 40,
   parameter bit ADC_OFFSET_BIN = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             pulse_i,
   input  logic             branch_i,
   input  logic             adc_valid_i,
   input  logic [ADC_W-1:0] adc_data_i,
   input  logic             hold_i,
   input  logic [Q_W-1:0]   q_step_i,
   input  logic [RES_W-1:0] offset_i,
   output logic             res_valid_o,
   output logic [RES_W-1:0] res_data_o,
   output logic             res_ovf_o,
   output logic             res_hold_o
);
   import merger_pkg::*;

   localparam int FOLD_W = ADC_W + 1;

   generate
      if (RES_W < CNT_W + Q_W + 2 || RES_W < FOLD_W + 2) begin : g_bad_res
         $error("toggle_residue_merger: RES_W too narrow for product and residue");
      end
   endgenerate

   logic                    close;
   logic signed [CNT_W-1:0] cnt_nx;
   logic                    ovf_nx;
   logic signed [ADC_W:0]   fold, start;
   logic                    hold_q, hold_nx;
   logic signed [RES_W-1:0] cnt_e, q_e, end_e, start_e, off_e, merged;

   mrg_win_seq #(.WIN_SAMPLES(WIN_SAMPLES)) u_seq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(adc_valid_i),
      .close_o(close)
   );

   mrg_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pulse_i  (pulse_i),
      .dir_neg_i(branch_e'(branch_i) == BR_NEG),
      .clr_i    (close),
      .cnt_nx_o (cnt_nx),
      .ovf_nx_o (ovf_nx)
   );

   mrg_residue #(.ADC_W(ADC_W), .OFFSET_BIN(ADC_OFFSET_BIN)) u_res (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sample_i (adc_data_i),
      .branch_i (branch_i),
      .capture_i(close),
      .fold_o   (fold),
      .start_o  (start)
   );

   always_comb begin
      hold_nx = hold_q | hold_i;
      cnt_e   = {{(RES_W - CNT_W){cnt_nx[CNT_W-1]}}, cnt_nx};
      q_e     = {{(RES_W - Q_W){1'b0}}, q_step_i};
      end_e   = {{(RES_W - FOLD_W){fold[ADC_W]}}, fold};
      start_e = {{(RES_W - FOLD_W){start[ADC_W]}}, start};
      off_e   = offset_i;
      merged  = (cnt_e * q_e) + (end_e - start_e) - off_e;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hold_q      <= 1'b0;
         res_valid_o <= 1'b0;
         res_data_o  <= '0;
         res_ovf_o   <= 1'b0;
         res_hold_o  <= 1'b0;
      end else begin
         hold_q      <= close ? 1'b0 : hold_nx;
         res_valid_o <= close;
         if (close) begin
            res_data_o <= hold_nx ? '0 : merged;
            res_ovf_o  <= hold_nx ? 1'b0 : ovf_nx;
            res_hold_o <= hold_nx;
         end else begin
            res_ovf_o  <= 1'b0;
            res_hold_o <= 1'b0;
         end
      end
   end

   // R2
   single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_valid_o |=> !res_valid_o);
   // R2
   strobe_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !adc_valid_i |=> !res_valid_o);
   // R8
   marker_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_hold_o |-> (res_valid_o && !res_ovf_o && res_data_o == '0));
   // R7
   ovf_with_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_ovf_o |-> res_valid_o);
endmodule

// File: tb/toggle_residue_merger_test.sv
module toggle_residue_merger_test;
   localparam int CLK_PERIOD = 10;
   localparam int ADC_W = 16;
   localparam int WIN   = 20;
   localparam int CW    = 6;
   localparam int QW    = 16;
   localparam int RW    = 40;
   localparam longint CMAX = (64'sd1 <<< (CW - 1)) - 1;
   localparam longint CMIN = -(64'sd1 <<< (CW - 1));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pulse = 1'b0, branch = 1'b0, valid = 1'b0, hold = 1'b0;
   logic [ADC_W-1:0] data = '0;
   logic [QW-1:0] qstep = 16'd100;
   logic [RW-1:0] offset = '0;
   logic res_valid, res_ovf, res_hold;
   logic [RW-1:0] res_data;

   int checks = 0, failures = 0;

   // reference state
   longint m_cnt = 0, m_start = 0;
   bit m_ovf = 0, m_hold = 0;
   int m_idx = 0;
   bit e_valid = 0, e_ovf = 0, e_hold = 0;
   longint e_data = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   toggle_residue_merger #(
      .ADC_W(ADC_W), .WIN_SAMPLES(WIN), .CNT_W(CW), .Q_W(QW), .RES_W(RW), .ADC_OFFSET_BIN(1'b0)
   ) uut (
      .clk_i(clk), .rst_ni(rst_n), .pulse_i(pulse), .branch_i(branch),
      .adc_valid_i(valid), .adc_data_i(data), .hold_i(hold),
      .q_step_i(qstep), .offset_i(offset),
      .res_valid_o(res_valid), .res_data_o(res_data),
      .res_ovf_o(res_ovf), .res_hold_o(res_hold)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // reference model advance for the inputs now on the pins
   task automatic model_step();
      longint n, f, d;
      bit o, h, cl;
      n = m_cnt;
      o = m_ovf;
      if (pulse) n = branch ? n - 1 : n + 1;          // R4
      if (n > CMAX) begin n = CMAX; o = 1; end        // R7
      if (n < CMIN) begin n = CMIN; o = 1; end
      h = m_hold | hold;                              // R8
      d = longint'($signed(data));
      f = branch ? -d : d;                            // R5
      cl = valid && (m_idx == WIN - 1);               // R2
      e_valid = cl;
      if (cl) begin
         e_hold = h;
         e_ovf  = h ? 1'b0 : o;
         e_data = h ? 0 : (n * longint'(qstep) + (f - m_start) - longint'($signed(offset)));
         m_start = f;                                 // R6
         m_cnt = 0; m_ovf = 0; m_hold = 0; m_idx = 0;
      end else begin
         e_ovf = 0; e_hold = 0;
         m_cnt = n; m_ovf = o; m_hold = h;
         if (valid) m_idx++;
      end
   endtask

   task automatic compare();
      check(res_valid == e_valid, "R2", longint'(res_valid), longint'(e_valid));
      if (e_valid && res_valid) begin
         check(res_hold == e_hold, "R8", longint'(res_hold), longint'(e_hold));
         check(res_ovf == e_ovf, "R7", longint'(res_ovf), longint'(e_ovf));
         check(longint'($signed(res_data)) == e_data,
               e_hold ? "R8" : "R3/R4/R5/R6", longint'($signed(res_data)), e_data);
      end
   endtask

   // one clock: drive at negedge, model, then compare after the edge
   task automatic cycle(input bit p, input bit b, input bit v, input bit h, input logic [ADC_W-1:0] dv);
      pulse = p; branch = b; valid = v; hold = h; data = dv;
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   function automatic logic [ADC_W-1:0] pick_data();
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) return 16'h8000;
      if (r == 1) return 16'h7FFF;
      return ADC_W'($urandom);
   endfunction

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R1 reset state
      check(res_valid == 1'b0 && res_ovf == 1'b0 && res_hold == 1'b0 && res_data == '0,
            "R1", longint'(res_data), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // mixed traffic, R3 R4 R5 R6
      for (int i = 0; i < 1500; i++) begin
         if (i % 300 == 0) begin
            qstep  = QW'($urandom);
            offset = RW'(longint'($urandom_range(0, 2000)) - 1000);
         end
         cycle($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
               $urandom_range(0, 1) == 1, 1'b0, pick_data());
      end
      // pulses in every cycle, samples every cycle: closing-cycle pulse ownership, R4
      for (int i = 0; i < 200; i++)
         cycle(1'b1, $urandom_range(0, 1) == 1, 1'b1, 1'b0, pick_data());
      // positive saturation, R7
      for (int i = 0; i < 400; i++)
         cycle(1'b1, 1'b0, $urandom_range(0, 3) == 0, 1'b0, pick_data());
      // negative saturation, R7
      for (int i = 0; i < 400; i++)
         cycle(1'b1, 1'b1, $urandom_range(0, 3) == 0, 1'b0, pick_data());
      // sparse hold pulses, often off sample cycles, R8
      for (int i = 0; i < 1200; i++)
         cycle($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
               $urandom_range(0, 1) == 1, $urandom_range(0, 40) == 0, pick_data());
      // quiet tail: windows with no pulses, residue only, R5 R6
      for (int i = 0; i < 300; i++)
         cycle(1'b0, $urandom_range(0, 1) == 1, 1'b1, 1'b0, pick_data());

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule